// File: doc/BRIEF.md
# Streaming Adjacent-Column Edge Detector

This block sits on the serial readout path of an image sensor. Pixel codes arrive one per valid cycle, in column order, one row after another. The block holds the code of the previous column. It compares only the upper bits of each new code with the upper bits of that stored code. This finds vertical edges as the pixels stream past, with no row buffer and no two-dimensional kernel.

A mode input picks the output for each pixel. In image mode the 8-bit code passes through unchanged. In edge mode the block emits a 1-bit flag instead. The threshold select sets how many low bits are ignored: 3, 4 or 5, for steps of 8, 16 or 32 codes. A carry correction covers values such as 0x07 followed by 0x08. When the highest ignored bit of the previous code is set and the compared field rises by exactly one, no edge is flagged. A start-of-row marker tells the block that a pixel has no left neighbour.

Top module: `col_edge_stream`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `out_valid`, `out_flag` and `out_code` are all 0.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock, in both modes.
- R3: Image mode (`edge_mode`=0) works as follows. A pixel accepted in one cycle appears on `out_code` in the next cycle with the same value, and `out_flag` is 0.
- R4: In edge mode (`edge_mode`=1), `out_code` is 0 for every output pixel.
- R5: With `thr_sel`=0 (step 8), bits [7:3] are compared. Any difference flags an edge, except in the carry case of R8. `thr_sel`=3 behaves the same as 0.
- R6: With `thr_sel`=1 (step 16), bits [7:4] are compared. A difference confined to bits [3:0] gives no edge.
- R7: With `thr_sel`=2 (step 32), bits [7:5] are compared. A difference confined to bits [4:0] gives no edge.
- R8: Carry correction: no edge is flagged when both of these hold:
  - the previous code's bit just below the compared field is 1;
  - the current compared field equals the previous field plus one.
- R9: A pixel marked with `in_sor` always gives `out_flag`=0, whatever the previous row ended with.
- R10: Cycles with `in_valid`=0 produce no output and leave the stored previous code unchanged. Within a row, the pixel after a gap is still compared with the last accepted pixel.
- R11: Whenever `out_valid` is 0, `out_flag` and `out_code` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel code present this cycle |
| in_sor | input | 1 | Pixel is the first of its row |
| in_code | input | 8 | Pixel code |
| edge_mode | input | 1 | 1: edge flag output, 0: image output |
| thr_sel | input | 2 | 0/3: step 8, 1: step 16, 2: step 32 |
| out_valid | output | 1 | Result present this cycle |
| out_flag | output | 1 | Edge flag (edge mode only) |
| out_code | output | 8 | Passed-through code (image mode only) |

## Verification
The only internal state is the stored previous code. A wrong value there shows up one clock later as a wrong `out_flag` on the next valid pixel of the same row. It stays hidden in image mode and at row starts. For that reason the edge-mode sequences chain pixels that sit just across each field boundary. They include gaps and mid-row threshold changes, so a stale, cleared or shifted stored value changes a flag at once. A wrong choice of field boundary or carry bit is exposed by code pairs that differ only inside the ignored bits, or that cross the boundary by one carry.

// File: rtl/edge_pkg.sv
package edge_pkg;
    localparam int PIX_W    = 8;
    localparam int BASE_LSB = 3;
    localparam int N_THR    = 3;
    localparam int SEL_W    = 2;

    typedef enum logic [SEL_W-1:0] {
        THR_STEP8  = 2'd0,
        THR_STEP16 = 2'd1,
        THR_STEP32 = 2'd2,
        THR_ALT8   = 2'd3
    } thr_sel_e;

    typedef struct packed {
        logic             vld;
        logic             sor;
        logic             emode;
        logic [PIX_W-1:0] code;
    } pix_in_t;

    typedef struct packed {
        logic             vld;
        logic             flag;
        logic [PIX_W-1:0] code;
    } pix_out_t;

    function automatic int thr_index(input logic [SEL_W-1:0] sel);
        int idx;
        idx = int'(sel);
        if (idx >= N_THR) idx = 0;
        return idx;
    endfunction
endpackage

// File: rtl/edge_prev_store.sv
module edge_prev_store
    import edge_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pix_in_t          pix,
    output logic [PIX_W-1:0] prev_code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_code <= '0;
        end else if (pix.vld) begin
            prev_code <= pix.code;
        end
    end
endmodule

// File: rtl/edge_cmp.sv
module edge_cmp
    import edge_pkg::*;
#(
    parameter int W    = PIX_W,
    parameter int LSB0 = BASE_LSB,
    parameter int NT   = N_THR
) (
    input  logic [W-1:0]     prev_code,
    input  logic [W-1:0]     cur_code,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    logic [NT-1:0] hits;

    for (genvar g = 0; g < NT; g++) begin : g_thr
        localparam int L  = LSB0 + g;
        localparam int FW = W - L;
        logic [FW-1:0] pf, cf;
        logic [FW:0]   pf_inc;
        logic          carry_bit, differs, carry_only;

        assign pf         = prev_code[W-1:L];
        assign cf         = cur_code[W-1:L];
        assign carry_bit  = prev_code[L-1];
        assign pf_inc     = {1'b0, pf} + {{FW{1'b0}}, 1'b1};
        assign differs    = (pf != cf);
        assign carry_only = carry_bit && ({1'b0, cf} == pf_inc);
        assign hits[g]    = differs && !carry_only;
    end

    always_comb begin
        hit = hits[thr_index(sel)];
    end
endmodule

// File: rtl/edge_out_stage.sv
module edge_out_stage
    import edge_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pix_in_t  pix,
    input  logic     hit,
    output pix_out_t res
);
    pix_out_t nxt;

    always_comb begin
        nxt      = '0;
        nxt.vld  = pix.vld;
        if (pix.vld) begin
            if (pix.emode) begin
                nxt.flag = hit && !pix.sor;
            end else begin
                nxt.code = pix.code;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res <= '0;
        else     res <= nxt;
    end
endmodule

// File: rtl/col_edge_stream.sv
module col_edge_stream
    import edge_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sor,
    input  logic [PIX_W-1:0] in_code,
    input  logic             edge_mode,
    input  logic [SEL_W-1:0] thr_sel,
    output logic             out_valid,
    output logic             out_flag,
    output logic [PIX_W-1:0] out_code
);
    pix_in_t          pix;
    pix_out_t         res;
    logic [PIX_W-1:0] prev_code;
    logic             hit;

    assign pix = '{vld: in_valid, sor: in_sor, emode: edge_mode, code: in_code};

    edge_prev_store u_prev (
        .clk       (clk),
        .rst       (rst),
        .pix       (pix),
        .prev_code (prev_code)
    );

    edge_cmp #(.W(PIX_W), .LSB0(BASE_LSB), .NT(N_THR)) u_cmp (
        .prev_code (prev_code),
        .cur_code  (in_code),
        .sel       (thr_sel),
        .hit       (hit)
    );

    edge_out_stage u_out (
        .clk (clk),
        .rst (rst),
        .pix (pix),
        .hit (hit),
        .res (res)
    );

    assign out_valid = res.vld;
    assign out_flag  = res.flag;
    assign out_code  = res.code;
endmodule

// File: rtl/col_edge_stream_chk.sv
module col_edge_stream_chk
    import edge_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_sor,
    input logic [PIX_W-1:0] in_code,
    input logic             edge_mode,
    input logic             out_valid,
    input logic             out_flag,
    input logic [PIX_W-1:0] out_code
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_flag && out_code == '0));

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_image_pass_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !edge_mode) |=> (out_code == $past(in_code) && !out_flag));

    assert_edge_code_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && edge_mode) |=> (out_code == '0));

    assert_row_start_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sor) |=> !out_flag);

    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_flag && out_code == '0));
endmodule

bind col_edge_stream col_edge_stream_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sor    (in_sor),
    .in_code   (in_code),
    .edge_mode (edge_mode),
    .out_valid (out_valid),
    .out_flag  (out_flag),
    .out_code  (out_code)
);

// File: tb/test_col_edge_stream.sv
module test_col_edge_stream;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_sor = 1'b0;
    logic [7:0] in_code = 8'h00;
    logic       edge_mode = 1'b0;
    logic [1:0] thr_sel = 2'd0;
    logic       out_valid;
    logic       out_flag;
    logic [7:0] out_code;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl_prev = 8'h00;
    logic [8:0] exp_q[$];
    string      tag_q[$];
    bit         mon_on = 1'b0;

    always #2 clk = ~clk;

    col_edge_stream i_col_edge_stream (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sor(in_sor),
        .in_code(in_code), .edge_mode(edge_mode), .thr_sel(thr_sel),
        .out_valid(out_valid), .out_flag(out_flag), .out_code(out_code)
    );

    function automatic logic model_flag(input logic [7:0] p, input logic [7:0] c,
                                        input logic [1:0] sel);
        int k;
        int pf, cf;
        k  = (sel == 2'd1) ? 4 : (sel == 2'd2) ? 5 : 3;
        pf = int'(p) >> k;
        cf = int'(c) >> k;
        return (pf != cf) && !(p[k-1] && cf == pf + 1);
    endfunction

    task automatic drive(input bit v, input bit sor, input logic [7:0] code,
                         input bit em, input logic [1:0] sel, input string tag);
        logic f;
        @(negedge clk);
        in_valid = v; in_sor = sor; in_code = code; edge_mode = em; thr_sel = sel;
        if (v) begin
            f = (em && !sor) ? model_flag(mdl_prev, code, sel) : 1'b0;
            exp_q.push_back(em ? {f, 8'h00} : {1'b0, code});
            tag_q.push_back(tag);
            mdl_prev = code;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 8'h00, 1'b0, 2'd0, "");
    endtask

    always @(posedge clk) begin
        #1;
        if (mon_on) begin
            if (out_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R2 unexpected out_valid: actual 1 expected 0");
                end else begin
                    logic [8:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if ({out_flag, out_code} !== e) begin
                        errors++;
                        $display("FAIL %s flag/code actual %b/%h expected %b/%h",
                                 t, out_flag, out_code, e[8], e[7:0]);
                    end
                end
            end else begin
                checks++;
                if (out_flag !== 1'b0 || out_code !== 8'h00) begin
                    errors++;
                    $display("FAIL R11 idle outputs actual %b/%h expected 0/00",
                             out_flag, out_code);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_flag !== 1'b0 || out_code !== 8'h00) begin
            errors++;
            $display("FAIL R1 reset outputs actual %b/%b/%h expected 0/0/00",
                     out_valid, out_flag, out_code);
        end
        @(negedge clk);
        rst = 1'b0;
        mon_on = 1'b1;

        // R3 image mode pass-through, R2 latency
        drive(1, 1, 8'h0A, 0, 2'd0, "R3");
        drive(1, 0, 8'hC8, 0, 2'd0, "R3");
        drive(1, 0, 8'h25, 0, 2'd1, "R2");
        idle(2);

        // R5 step 8, R4 code zero, R8 carry correction
        drive(1, 1, 8'h01, 1, 2'd0, "R9");
        drive(1, 0, 8'h6E, 1, 2'd0, "R5");
        drive(1, 0, 8'h6F, 1, 2'd0, "R5");
        drive(1, 0, 8'h70, 1, 2'd0, "R8");
        drive(1, 0, 8'h77, 1, 2'd0, "R5");
        drive(1, 0, 8'h76, 1, 2'd0, "R5");
        drive(1, 0, 8'h86, 1, 2'd0, "R5");
        drive(1, 0, 8'h07, 1, 2'd0, "R4");
        drive(1, 0, 8'h08, 1, 2'd0, "R8");
        drive(1, 0, 8'h10, 1, 2'd3, "R5");
        drive(1, 0, 8'h17, 1, 2'd3, "R5");

        // R6 step 16
        drive(1, 1, 8'h10, 1, 2'd1, "R9");
        drive(1, 0, 8'h18, 1, 2'd1, "R6");
        drive(1, 0, 8'h28, 1, 2'd1, "R8");
        drive(1, 0, 8'h48, 1, 2'd1, "R6");
        drive(1, 0, 8'h30, 1, 2'd1, "R6");

        // R7 step 32
        drive(1, 1, 8'h20, 1, 2'd2, "R9");
        drive(1, 0, 8'h30, 1, 2'd2, "R7");
        drive(1, 0, 8'h50, 1, 2'd2, "R8");
        drive(1, 0, 8'h90, 1, 2'd2, "R7");
        drive(1, 0, 8'h9F, 1, 2'd2, "R7");

        // R9 row start after large jump
        drive(1, 1, 8'hFF, 1, 2'd0, "R9");
        drive(1, 0, 8'h00, 1, 2'd0, "R5");
        drive(1, 1, 8'h80, 1, 2'd0, "R9");

        // R10 gaps keep the stored code
        drive(1, 0, 8'h10, 1, 2'd0, "R10");
        idle(3);
        drive(1, 0, 8'h40, 1, 2'd0, "R10");
        idle(2);
        drive(1, 0, 8'h41, 1, 2'd0, "R10");
        drive(0, 1, 8'hEE, 1, 2'd0, "");
        drive(1, 0, 8'hC0, 1, 2'd0, "R10");

        // mode switch inside a row keeps comparison on stored code
        drive(1, 0, 8'h33, 0, 2'd0, "R3");
        drive(1, 0, 8'h3B, 1, 2'd0, "R8");
        drive(1, 0, 8'h3C, 1, 2'd2, "R7");

        idle(4);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 missing outputs actual %0d pending expected 0", exp_q.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule